// File: doc/BRIEF.md
# Transmit Frame Terminator with Forced FCS Error

This block sits in a byte-wide transmit path between a frame source and the line. It forwards the bytes of each frame, keeps a running CRC-32 over them, counts how many bytes of the frame have already gone out, and closes each frame itself. On a normal end of frame it appends the four frame check sequence bytes. When the source asks to abandon a frame part way through, the block decides how to end it. It looks at how much of the frame has already left.

If the frame is still shorter than the minimum frame length (512 bits by default), output stops at once and the line carries a runt. If the frame is already at least that long, the block appends the bitwise inverse of the correct FCS, starting at the next byte slot. Any receiver then sees a bad FCS and discards the frame. After an abort, input is discarded until the next start-of-frame marker.

Top module: `tx_frame_terminator`

## Requirements
- R1: While reset is held, and in the first cycle after it, out_valid and out_eof are 0.
- R2: A byte is accepted when in_valid and in_sof are 1 with no frame open, or when in_valid is 1 inside an open frame with abort_req at 0. An accepted byte appears unchanged on out_data with out_valid=1 one clock later. Cycles without in_valid inside a frame produce cycles without out_valid.
- R3: After the byte marked with in_eof, four FCS bytes follow in consecutive cycles. The FCS is the complement of a CRC-32 over the frame bytes, using reflected polynomial 0xEDB88320 with the register preset to all ones. It is sent least significant byte first, and out_eof is 1 only on the fourth byte. For the ASCII frame "123456789" the bytes are 26 39 F4 CB.
- R4: If abort_req arrives in an open frame after fewer than MIN_BITS/8 bytes have been emitted (64 by default), the frame emits nothing more.
- R5: If abort_req arrives in an open frame after at least MIN_BITS/8 bytes, the very next output cycle starts four bytes. Together they are the bitwise inverse of the R3 FCS over the bytes already emitted, least significant byte first, with out_eof on the fourth.
- R6: The byte presented in the same cycle as an accepted abort is neither emitted nor folded into the CRC.
- R7: Once a frame has ended or been aborted, bytes without in_sof are dropped. The next in_sof starts a fresh CRC and a fresh byte count.
- R8: While FCS bytes are being sent, in_valid, in_sof, in_eof and abort_req are ignored.
- R9: abort_req has no effect when no frame is open. This includes the cycle in which in_sof opens a frame.
- R10: The threshold is exact: an abort after 63 emitted bytes gives a runt, and an abort after 64 gives the inverted FCS.
- R11: out_eof is never 1 while out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| abort_req | input | 1 | Request to abandon the open frame |
| out_valid | output | 1 | Output byte present |
| out_eof | output | 1 | Output byte is the last of the frame |
| out_data | output | 8 | Output byte |

## Verification
The hardest situations to reach are aborts right at the length threshold, and activity on the inputs while the closing FCS bytes are streaming out. The driver builds frames of exact lengths (63, 64 and 100 bytes) and raises the abort in the cycle after the last counted byte. That abort cycle also carries a decoy byte, which must not appear. During each tail the driver also presents stray bytes, start markers and aborts, and the scoreboard must see the tail unchanged. The CRC is anchored by a frame whose FCS bytes are written as literal values, not computed.

// File: rtl/txfa_pkg.sv
// Package: shared types, constants and the CRC-32 byte step for the
// transmit frame terminator. Assumes byte-wide data and a 32-bit FCS.
package txfa_pkg;

    localparam int BYTE_W    = 8;
    localparam int CRC_W     = 32;
    localparam int FCS_BYTES = CRC_W / BYTE_W;
    localparam logic [CRC_W-1:0] CRC_PRESET    = '1;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

    // Frame state: no frame open, frame open, FCS tail streaming
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_TAIL = 2'd2
    } tx_state_e;

    // Advance a reflected CRC-32 register by one byte, LSB first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                  input logic [BYTE_W-1:0] data);
        logic [CRC_W-1:0] r;
        r = cur;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ data[i])
                r = (r >> 1) ^ CRC_POLY_REFL;
            else
                r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/txfa_crc.sv
// Running CRC-32 register. 'start' seeds the register from the preset and
// folds in the first byte; 'advance' folds in a further byte. Otherwise the
// value holds. Assumes start and advance are never high together.
module txfa_crc
    import txfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              advance,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc_q
);

    // Update the running CRC with each accepted frame byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= CRC_PRESET;
        else if (start)
            crc_q <= crc_step(CRC_PRESET, data);
        else if (advance)
            crc_q <= crc_step(crc_q, data);
    end

    // R6: a byte that is not accepted leaves the CRC untouched
    p_crc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !advance) |=> $stable(crc_q));

endmodule

// File: rtl/txfa_bytecnt.sv
// Counts the bytes emitted in the current frame, saturating at the
// minimum frame length. 'reached' is high once MIN_BITS bits have gone out.
// Assumes MIN_BITS is a multiple of eight.
module txfa_bytecnt #(
    parameter int MIN_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic advance,
    output logic reached
);

    localparam int MIN_BYTES = MIN_BITS / 8;
    localparam int CNT_W     = $clog2(MIN_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_BYTES);

    logic [CNT_W-1:0] cnt_q;

    // Restart at one on a frame start, count up to the threshold and stop
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(1);
        else if (advance && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    // Threshold comparison on the saturated count
    always_comb reached = (cnt_q == CNT_MAX);

    // R10: once the threshold is reached it stays reached until a new frame
    p_reach_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && !start) |=> reached);

endmodule

// File: rtl/txfa_fcs_sel.sv
// Picks one FCS byte from the running CRC. With 'inv' low it yields the
// correct FCS (complement of the CRC); with 'inv' high it yields the
// inverse of that. 'last' marks the final FCS byte. Purely combinational.
module txfa_fcs_sel
    import txfa_pkg::*;
#(
    parameter int IDX_W = $clog2(FCS_BYTES)
) (
    input  logic [CRC_W-1:0]  crc,
    input  logic              inv,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] fcs_byte,
    output logic              last
);

    logic [CRC_W-1:0] word;

    // Form the FCS word and slice the requested byte, LSB first
    always_comb begin
        word     = inv ? crc : ~crc;
        fcs_byte = word[idx*BYTE_W +: BYTE_W];
        last     = (idx == IDX_W'(FCS_BYTES - 1));
    end

endmodule

// File: rtl/tx_frame_terminator.sv
// Transmit frame terminator. Forwards frame bytes with one cycle of latency
// and closes each frame with its FCS. On abort it either cuts the frame
// (runt) or, once MIN_BITS bits are out, sends the inverted FCS at the next
// byte slot. Assumes the source never needs backpressure.
module tx_frame_terminator
    import txfa_pkg::*;
#(
    parameter int MIN_BITS = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [7:0]  in_data,
    input  logic        abort_req,
    output logic        out_valid,
    output logic        out_eof,
    output logic [7:0]  out_data
);

    localparam int IDX_W = $clog2(FCS_BYTES);

    tx_state_e         state_q;
    logic              inv_q;
    logic [IDX_W-1:0]  idx_q;
    logic              crc_start;
    logic              crc_adv;
    logic [CRC_W-1:0]  crc_q;
    logic              reached;
    logic [BYTE_W-1:0] fcs_byte;
    logic              fcs_last;

    // Acceptance strobes that feed both the CRC and the byte counter
    always_comb begin
        crc_start = (state_q == ST_IDLE) && in_valid && in_sof;
        crc_adv   = (state_q == ST_PASS) && in_valid && !abort_req;
    end

    txfa_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (crc_start),
        .advance (crc_adv),
        .data    (in_data),
        .crc_q   (crc_q)
    );

    txfa_bytecnt #(.MIN_BITS(MIN_BITS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (crc_start),
        .advance (crc_adv),
        .reached (reached)
    );

    txfa_fcs_sel #(.IDX_W(IDX_W)) u_sel (
        .crc      (crc_q),
        .inv      (inv_q),
        .idx      (idx_q),
        .fcs_byte (fcs_byte),
        .last     (fcs_last)
    );

    // Frame state machine and registered output byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            inv_q     <= 1'b0;
            idx_q     <= '0;
            out_valid <= 1'b0;
            out_eof   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_eof   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (in_valid && in_sof) begin
                        out_valid <= 1'b1;
                        out_data  <= in_data;
                        inv_q     <= 1'b0;
                        idx_q     <= '0;
                        state_q   <= in_eof ? ST_TAIL : ST_PASS;
                    end
                end
                ST_PASS: begin
                    if (abort_req) begin
                        if (reached) begin
                            out_valid <= 1'b1;
                            out_data  <= crc_q[BYTE_W-1:0];
                            inv_q     <= 1'b1;
                            idx_q     <= IDX_W'(1);
                            state_q   <= ST_TAIL;
                        end else begin
                            state_q   <= ST_IDLE;
                        end
                    end else if (in_valid) begin
                        out_valid <= 1'b1;
                        out_data  <= in_data;
                        if (in_eof) begin
                            inv_q   <= 1'b0;
                            idx_q   <= '0;
                            state_q <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    out_valid <= 1'b1;
                    out_data  <= fcs_byte;
                    out_eof   <= fcs_last;
                    idx_q     <= idx_q + 1'b1;
                    if (fcs_last)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: an accepted in-frame byte shows up unchanged one cycle later
    p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && in_valid && !abort_req) |=>
            (out_valid && out_data == $past(in_data)));

    // R3: a frame end is preceded by three further valid tail bytes
    p_tail_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> ($past(out_valid, 1) && $past(out_valid, 2) && $past(out_valid, 3)));

    // R4: a short frame that is aborted goes silent
    p_runt_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && abort_req && !reached) |=> !out_valid);

    // R5: a long frame that is aborted emits a tail byte in the next slot
    p_inv_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && abort_req && reached) |=> (out_valid && !out_eof));

    // R7: with no frame open, only a start marker produces output
    p_idle_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(in_valid && in_sof)) |=> !out_valid);

    // R8: the tail streams without gaps whatever the inputs do
    p_tail_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL) |=> out_valid);

    // R11: end marker only on a valid byte
    p_eof_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

endmodule

// File: tb/tx_frame_terminator_tb.sv
// Scoreboard bench: driver tasks queue the expected output bytes and a
// monitor pops and compares them at each falling edge.
module tx_frame_terminator_tb;

    localparam logic [31:0] POLY = 32'hEDB88320;

    typedef struct {
        logic [7:0] d;
        logic       e;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       abort_req = 1'b0;
    logic       out_valid;
    logic       out_eof;
    logic [7:0] out_data;

    exp_t  q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    tx_frame_terminator u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_data   (in_data),
        .abort_req (abort_req),
        .out_valid (out_valid),
        .out_eof   (out_eof),
        .out_data  (out_data)
    );

    // Bench model of the reflected CRC-32 register, bit by bit
    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int b = 0; b < 8; b++) begin
            fb = r[0] ^ d[b];
            r  = {1'b0, r[31:1]};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed * 7 + i * 13 + (i >> 3));
    endfunction

    task automatic push(input logic [7:0] d, input logic e, input string tag);
        exp_t x;
        x.d = d; x.e = e; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic push_word(input logic [31:0] w, input string tag);
        for (int k = 0; k < 4; k++)
            push(w[k*8 +: 8], k == 3, tag);
    endtask

    task automatic put(input logic v, input logic s, input logic e,
                       input logic [7:0] d, input logic ab);
        in_valid = v; in_sof = s; in_eof = e; in_data = d; abort_req = ab;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) put(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    // Complete frame; options: gaps, noisy tail, abort raised with sof
    task automatic send_frame(input int n, input int seed, input string tag,
                              input bit gaps, input bit noisy, input bit ab_sof);
        logic [31:0] c;
        logic [7:0]  d;
        c = 32'hFFFF_FFFF;
        cur_tag = tag;
        for (int i = 0; i < n; i++) begin
            d = pat(seed, i);
            push(d, 1'b0, tag);
            c = ref_crc(c, d);
            put(1'b1, i == 0, i == n - 1, d, ab_sof && i == 0);
            if (gaps && (i % 3 == 2) && i != n - 1) idle(1);
        end
        push_word(~c, tag);
        if (noisy) begin
            // R8: stray bytes, start markers and aborts during the tail
            for (int k = 0; k < 4; k++) put(1'b1, k == 1, k == 2, 8'h3C, 1'b1);
        end else begin
            idle(4);
        end
        idle(2);
    endtask

    // Frame cut by abort after n bytes; the abort cycle carries a decoy byte
    task automatic abort_frame(input int n, input int seed, input string tag);
        logic [31:0] c;
        logic [7:0]  d;
        c = 32'hFFFF_FFFF;
        cur_tag = tag;
        for (int i = 0; i < n; i++) begin
            d = pat(seed, i);
            push(d, 1'b0, tag);
            c = ref_crc(c, d);
            put(1'b1, i == 0, 1'b0, d, 1'b0);
        end
        // R6: the decoy byte must not be emitted nor enter the CRC
        if (n >= 64) push_word(c, tag);
        put(1'b1, 1'b0, 1'b0, 8'hA5, 1'b1);
        idle(5);
        // R7: bytes without a start marker are dropped after the abort
        cur_tag = "R7";
        for (int k = 0; k < 3; k++) put(1'b1, 1'b0, k == 2, 8'h5A, 1'b0);
        idle(2);
    endtask

    // Monitor: pop and compare each produced byte
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_eof && !out_valid) begin
                checks++; failures++;
                $display("FAIL R11: out_eof=1 out_valid=0 expected out_valid=1");
            end
            if (out_valid) begin
                checks++;
                if (q.size() == 0) begin
                    failures++;
                    $display("FAIL %s: unexpected byte %02h eof=%0b expected no output",
                             cur_tag, out_data, out_eof);
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    if (out_data !== x.d || out_eof !== x.e) begin
                        failures++;
                        $display("FAIL %s: data=%02h eof=%0b expected data=%02h eof=%0b",
                                 x.tag, out_data, out_eof, x.d, x.e);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset holds the outputs low even with input activity
        in_valid = 1'b1; in_sof = 1'b1; in_data = 8'h77;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_eof !== 1'b0) begin
            failures++;
            $display("FAIL R1: out_valid=%0b out_eof=%0b expected 0 0", out_valid, out_eof);
        end
        in_valid = 1'b0; in_sof = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_eof !== 1'b0) begin
            failures++;
            $display("FAIL R1: after release out_valid=%0b out_eof=%0b expected 0 0",
                     out_valid, out_eof);
        end

        // R3: literal FCS anchor for "123456789"
        cur_tag = "R3";
        for (int i = 0; i < 9; i++) begin
            push(8'h31 + 8'(i), 1'b0, "R3");
            put(1'b1, i == 0, i == 8, 8'h31 + 8'(i), 1'b0);
        end
        push(8'h26, 1'b0, "R3"); push(8'h39, 1'b0, "R3");
        push(8'hF4, 1'b0, "R3"); push(8'hCB, 1'b1, "R3");
        idle(6);

        send_frame(10, 3, "R2", 1'b0, 1'b0, 1'b0);
        send_frame(1, 9, "R2 single byte", 1'b0, 1'b0, 1'b0);
        send_frame(17, 4, "R2 gaps", 1'b1, 1'b0, 1'b0);
        send_frame(12, 5, "R8", 1'b0, 1'b1, 1'b0);

        // R9: abort with no frame open, then abort together with sof
        cur_tag = "R9";
        for (int k = 0; k < 3; k++) put(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
        send_frame(8, 6, "R9", 1'b0, 1'b0, 1'b1);

        abort_frame(20, 7, "R4");
        send_frame(6, 8, "R7 fresh frame", 1'b0, 1'b0, 1'b0);
        abort_frame(63, 10, "R10 63 bytes");
        abort_frame(64, 11, "R10 64 bytes");
        abort_frame(100, 12, "R5");
        send_frame(70, 13, "R7 after inverted", 1'b0, 1'b0, 1'b0);

        idle(10);
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R3: %0d expected bytes never produced, expected 0", q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule